// File: doc/BRIEF.md
# Cross-Domain Register Write Synchronizer

This block sits between a register interface clocked by the bus clock and a peripheral core that runs on its own clock. The two clocks are unrelated and may differ widely in rate in either direction. A write to a register that lives in the core domain is held in the bus domain and handed across by a single toggle handshake. A two-flop synchronizer carries the request toggle into the core domain and another carries the acknowledge toggle back. A set of busy bits, readable at a dedicated address, shows which transfer is still in flight. A bus write that arrives while any transfer is in flight is stalled by holding `req_ready` low. It is never dropped. Registers that live only in the bus domain complete at once.

The control register has two fields. Bit 0 is the core enable. Bit 1 is a self-clearing software reset. Each field has its own busy bit. A software reset clears every core-domain register and the bus-side copies of them. Its busy bit stays set until the core domain has finished a reset phase of a fixed number of core cycles. While the interface clock gate input is low, no access completes and the bus stays blocked.

Address map, with NDATA data registers and NLOC local registers:

| Address | Register |
|---|---|
| 0 | control |
| 1..NDATA | synchronized data registers |
| NDATA+1..NDATA+NLOC | local registers |
| NDATA+NLOC+1 | read-only busy vector |

Top module: `xds_reg_sync`

## Requirements
- R1: A write accepted to address 0 or to a data address (1..NDATA) sets its busy bit by the next bus cycle. The bit stays set until the acknowledge for that transfer has come back.
- R2: Once the busy bits read zero, `core_data` slice k-1 (bits [(k-1)*DW +: DW]) holds the last value written to data address k, and `core_enable` holds the last enable written. The held request word stays stable while a transfer is busy.
- R3: A read of the busy address returns the busy vector. Bit 0 is software-reset busy, bit 1 is enable busy, and bit k+1 is busy for data address k. A write to the busy address has no effect.
- R4: A write presented while any busy bit is set sees `req_ready` low until all busy bits clear. It then completes, and its value reaches the core.
- R5: A write to a local address completes in the cycle it is presented, provided nothing is busy. It reads back its value and never sets a busy bit.
- R6: Reads complete without stall whenever the interface clock gate is on, including while a transfer is busy.
- R7: While `if_clk_on` is low, `req_ready` is low for every access and nothing is written. The held access completes once the gate turns on.
- R8: A control write sets bit 1 of the busy vector. If written bit 1 (software reset) is one, it also sets bit 0. Otherwise written bit 0 becomes the core enable. Control bit 1 always reads as zero.
- R9: A software reset clears `core_enable`, all of `core_data` and the bus-side copies of these registers, but not the local registers. `core_rst_active` is high for RST_CYCLES core cycles. Busy bit 0 clears only after that phase.
- R10: Transfers are correct both with the core clock much slower and with it faster than the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus-side clock |
| rst_bus_n | input | 1 | Bus-domain active-low reset, release synchronous to clk_bus |
| clk_core | input | 1 | Peripheral core clock |
| rst_core_n | input | 1 | Core-domain active-low reset, release synchronous to clk_core |
| if_clk_on | input | 1 | Interface clock gate; low blocks all accesses |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Access completes on a clock edge where valid and ready are both high |
| req_rdata | output | DW | Read data, valid while valid and ready are high |
| core_enable | output | 1 | Core-domain enable |
| core_data | output | NDATA*DW | Core-domain data registers, address 1 in the low slice |
| core_rst_active | output | 1 | Core-domain software reset phase in progress |

## Verification
A lost or stuck toggle in either direction shows up at the ports as a busy vector that never returns to zero. Every later write then stalls forever, so the very next polled write or idle wait exposes it within a few thousand bus cycles. A wrong or unstable held word, or a misrouted index, shows up as a `core_data` slice or a readback that differs from the last written value once the busy bits clear. A reset phase that ends early shows up as busy bit 0 clearing while `core_rst_active` is still high, or as core values that are not zero after the reset. These are compared after each random burst in both clock ratios.

// File: rtl/xds_pkg.sv
`timescale 1ns/1ps
package xds_pkg;

  typedef enum logic [2:0] {
    XC_CTRL,
    XC_DATA,
    XC_LOCAL,
    XC_BUSY,
    XC_NONE
  } xds_cls_e;

  // Map an address onto its register class for a given layout.
  function automatic xds_cls_e xds_classify(input int a, input int nd, input int nl);
    if (a == 0)                   return XC_CTRL;
    else if (a <= nd)             return XC_DATA;
    else if (a <= nd + nl)        return XC_LOCAL;
    else if (a == nd + nl + 1)    return XC_BUSY;
    else                          return XC_NONE;
  endfunction

endpackage

// File: rtl/xds_sync2.sv
`timescale 1ns/1ps
module xds_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/xds_bus_port.sv
`timescale 1ns/1ps
module xds_bus_port
  import xds_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter int NDATA = 3,
  parameter int NLOC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_clk_on,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] req_rdata,
  input  logic          ack_tgl_s,
  output logic          req_tgl,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data
);
  localparam int NB = NDATA + 2;

  logic [NB-1:0] busy_q, busy_d;
  logic          sh_en_q, sh_en_d;
  logic [DW-1:0] sh_data_q [NDATA];
  logic [DW-1:0] sh_data_d [NDATA];
  logic [DW-1:0] loc_q [NLOC];
  logic [DW-1:0] loc_d [NLOC];
  logic          tgl_q, tgl_d;
  logic          ack_seen_q, ack_seen_d;
  logic [AW-1:0] h_addr_q, h_addr_d;
  logic [DW-1:0] h_data_q, h_data_d;

  xds_cls_e cls;
  logic     busy_any;
  logic     fire_wr;
  logic     ack_evt;
  int       didx;
  int       lidx;

  assign cls      = xds_classify(int'(req_addr), NDATA, NLOC);
  assign busy_any = |busy_q;
  assign req_ready = if_clk_on && !(req_write && busy_any);
  assign fire_wr  = req_valid && req_ready && req_write;
  assign ack_evt  = (ack_tgl_s != ack_seen_q);

  // read mux
  always_comb begin
    req_rdata = '0;
    didx = int'(req_addr) - 1;
    lidx = int'(req_addr) - NDATA - 1;
    unique case (cls)
      XC_CTRL:  req_rdata[0] = sh_en_q;
      XC_DATA:  req_rdata = sh_data_q[didx];
      XC_LOCAL: req_rdata = loc_q[lidx];
      XC_BUSY:  req_rdata[NB-1:0] = busy_q;
      default:  req_rdata = '0;
    endcase
  end

  // next state
  always_comb begin
    busy_d     = busy_q;
    sh_en_d    = sh_en_q;
    sh_data_d  = sh_data_q;
    loc_d      = loc_q;
    tgl_d      = tgl_q;
    ack_seen_d = ack_seen_q;
    h_addr_d   = h_addr_q;
    h_data_d   = h_data_q;

    if (ack_evt) begin
      ack_seen_d = ack_tgl_s;
      busy_d     = '0;
      if (busy_q[0]) begin
        sh_en_d = 1'b0;
        for (int i = 0; i < NDATA; i++) sh_data_d[i] = '0;
      end
    end

    if (fire_wr) begin
      unique case (cls)
        XC_CTRL: begin
          busy_d[1] = 1'b1;
          busy_d[0] = req_wdata[1];
          if (!req_wdata[1]) sh_en_d = req_wdata[0];
          tgl_d    = ~tgl_q;
          h_addr_d = req_addr;
          h_data_d = req_wdata;
        end
        XC_DATA: begin
          busy_d[didx + 2] = 1'b1;
          sh_data_d[didx]  = req_wdata;
          tgl_d    = ~tgl_q;
          h_addr_d = req_addr;
          h_data_d = req_wdata;
        end
        XC_LOCAL: loc_d[lidx] = req_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= '0;
      sh_en_q    <= 1'b0;
      for (int i = 0; i < NDATA; i++) sh_data_q[i] <= '0;
      for (int i = 0; i < NLOC; i++)  loc_q[i] <= '0;
      tgl_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      h_addr_q   <= '0;
      h_data_q   <= '0;
    end else begin
      busy_q     <= busy_d;
      sh_en_q    <= sh_en_d;
      sh_data_q  <= sh_data_d;
      loc_q      <= loc_d;
      tgl_q      <= tgl_d;
      ack_seen_q <= ack_seen_d;
      h_addr_q   <= h_addr_d;
      h_data_q   <= h_data_d;
    end
  end

  assign req_tgl   = tgl_q;
  assign hold_addr = h_addr_q;
  assign hold_data = h_data_q;

  // R4: writes stall while a transfer is in flight
  a_r4_stall_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && busy_any) |-> !req_ready);

  // R7: gated interface clock blocks every access
  a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !if_clk_on |-> !req_ready);

  // R1: accepted synchronized write shows busy on the next cycle
  a_r1_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_wr && (cls == XC_CTRL || cls == XC_DATA)) |=> busy_any);

  // R2: held request word does not move while busy
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy_any |=> ($stable(h_data_q) && $stable(h_addr_q)));

  // R6: reads never stall while the gate is on
  a_r6_read_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && if_clk_on) |-> req_ready);

  // R5: local writes never raise busy
  a_r5_local_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_wr && cls == XC_LOCAL) |=> !busy_any);
endmodule

// File: rtl/xds_core_port.sv
`timescale 1ns/1ps
module xds_core_port #(
  parameter int DW         = 16,
  parameter int AW         = 4,
  parameter int NDATA      = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_tgl_s,
  input  logic [AW-1:0]       hold_addr,
  input  logic [DW-1:0]       hold_data,
  output logic                ack_tgl,
  output logic                core_enable,
  output logic [NDATA*DW-1:0] core_data,
  output logic                core_rst_active
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic          seen_q, seen_d;
  logic          ack_q, ack_d;
  logic          en_q, en_d;
  logic [DW-1:0] dat_q [NDATA];
  logic [DW-1:0] dat_d [NDATA];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          evt;
  int            didx;

  assign evt = (req_tgl_s != seen_q);

  always_comb begin
    seen_d = seen_q;
    ack_d  = ack_q;
    en_d   = en_q;
    dat_d  = dat_q;
    cnt_d  = cnt_q;
    didx   = int'(hold_addr) - 1;

    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) ack_d = ~ack_q;
    end

    if (evt) begin
      seen_d = req_tgl_s;
      if (hold_addr == '0) begin
        if (hold_data[1]) begin
          en_d  = 1'b0;
          for (int i = 0; i < NDATA; i++) dat_d[i] = '0;
          cnt_d = CW'(RST_CYCLES);
        end else begin
          en_d  = hold_data[0];
          ack_d = ~ack_q;
        end
      end else begin
        dat_d[didx] = hold_data;
        ack_d = ~ack_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      ack_q  <= 1'b0;
      en_q   <= 1'b0;
      for (int i = 0; i < NDATA; i++) dat_q[i] <= '0;
      cnt_q  <= '0;
    end else begin
      seen_q <= seen_d;
      ack_q  <= ack_d;
      en_q   <= en_d;
      dat_q  <= dat_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < NDATA; g++) begin : g_out
    assign core_data[g*DW +: DW] = dat_q[g];
  end

  assign ack_tgl         = ack_q;
  assign core_enable     = en_q;
  assign core_rst_active = (cnt_q != '0);

  // R9: core registers stay cleared during the reset phase
  a_r9_cleared_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_active |-> (!core_enable && core_data == '0));

  // R9: no new request can arrive before the reset phase is acknowledged
  a_r9_no_req_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_active |-> !evt);
endmodule

// File: rtl/xds_reg_sync.sv
`timescale 1ns/1ps
module xds_reg_sync #(
  parameter int DW         = 16,
  parameter int AW         = 4,
  parameter int NDATA      = 3,
  parameter int NLOC       = 2,
  parameter int RST_CYCLES = 4
) (
  input  logic                clk_bus,
  input  logic                rst_bus_n,
  input  logic                clk_core,
  input  logic                rst_core_n,
  input  logic                if_clk_on,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                req_ready,
  output logic [DW-1:0]       req_rdata,
  output logic                core_enable,
  output logic [NDATA*DW-1:0] core_data,
  output logic                core_rst_active
);
  logic          req_tgl, req_tgl_s;
  logic          ack_tgl, ack_tgl_s;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;

  xds_bus_port #(.DW(DW), .AW(AW), .NDATA(NDATA), .NLOC(NLOC)) u_bus (
    .clk(clk_bus), .rst_n(rst_bus_n), .if_clk_on(if_clk_on),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .ack_tgl_s(ack_tgl_s), .req_tgl(req_tgl),
    .hold_addr(hold_addr), .hold_data(hold_data)
  );

  xds_sync2 #(.W(1)) u_req_sync (
    .clk(clk_core), .rst_n(rst_core_n), .d(req_tgl), .q(req_tgl_s)
  );

  xds_sync2 #(.W(1)) u_ack_sync (
    .clk(clk_bus), .rst_n(rst_bus_n), .d(ack_tgl), .q(ack_tgl_s)
  );

  xds_core_port #(.DW(DW), .AW(AW), .NDATA(NDATA), .RST_CYCLES(RST_CYCLES)) u_core (
    .clk(clk_core), .rst_n(rst_core_n), .req_tgl_s(req_tgl_s),
    .hold_addr(hold_addr), .hold_data(hold_data), .ack_tgl(ack_tgl),
    .core_enable(core_enable), .core_data(core_data),
    .core_rst_active(core_rst_active)
  );
endmodule

// File: tb/sim_xds_reg_sync.sv
`timescale 1ns/1ps
module sim_xds_reg_sync;
  localparam int DW = 16, AW = 4, NDATA = 3, NLOC = 2, RSTC = 4;
  localparam int A_LOC0 = NDATA + 1;
  localparam int A_BUSY = NDATA + NLOC + 1;

  logic clk_bus = 1'b0, clk_core = 1'b0;
  logic rst_bus_n = 1'b0, rst_core_n = 1'b0;
  logic if_clk_on = 1'b1, req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready;
  logic [DW-1:0] req_rdata;
  logic core_enable, core_rst_active;
  logic [NDATA*DW-1:0] core_data;

  realtime core_half = 30.0;
  always #5 clk_bus = ~clk_bus;
  always #(core_half) clk_core = ~clk_core;

  xds_reg_sync #(.DW(DW), .AW(AW), .NDATA(NDATA), .NLOC(NLOC), .RST_CYCLES(RSTC)) u0 (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .clk_core(clk_core), .rst_core_n(rst_core_n),
    .if_clk_on(if_clk_on), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .core_enable(core_enable), .core_data(core_data),
    .core_rst_active(core_rst_active)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  bit saw_rst = 0;
  logic [DW-1:0] m_data [NDATA];
  logic m_en;
  logic [DW-1:0] m_loc [NLOC];

  always @(posedge clk_core) if (core_rst_active) saw_rst <= 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_busy(input int a, input logic [DW-1:0] d);
    if (a == 0) return 32'h2 | (d[1] ? 32'h1 : 32'h0);
    else if (a >= 1 && a <= NDATA) return 32'h1 << (a + 1);
    else return 32'h0;
  endfunction

  task automatic model_wr(input int a, input logic [DW-1:0] d);
    if (a == 0) begin
      if (d[1]) begin
        m_en = 1'b0;
        for (int i = 0; i < NDATA; i++) m_data[i] = '0;
      end else m_en = d[0];
    end else if (a <= NDATA) m_data[a-1] = d;
    else if (a <= NDATA + NLOC) m_loc[a-A_LOC0] = d;
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, output int stalls);
    @(negedge clk_bus);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    #1;
    stalls = 0;
    while (!req_ready) begin
      @(negedge clk_bus); #1; stalls++;
    end
    @(posedge clk_bus); #1;
    req_valid = 1'b0; req_write = 1'b0;
    model_wr(a, d);
  endtask

  task automatic do_read(input int a, output logic [DW-1:0] d, output int stalls);
    @(negedge clk_bus);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    #1;
    stalls = 0;
    while (!req_ready) begin
      @(negedge clk_bus); #1; stalls++;
    end
    d = req_rdata;
    @(posedge clk_bus); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [DW-1:0] b;
    int s, n;
    n = 0;
    do begin
      do_read(A_BUSY, b, s);
      n++;
    end while (b != '0 && n < 3000);
    chk(b == '0, tag, 32'(b), 32'h0);
  endtask

  task automatic check_all(input string tag);
    logic [DW-1:0] v;
    int s;
    wait_idle({tag, " R4 busy clears"});
    chk(core_enable == m_en, {tag, " R2 core_enable"}, 32'(core_enable), 32'(m_en));
    for (int i = 0; i < NDATA; i++) begin
      chk(core_data[i*DW +: DW] == m_data[i], {tag, " R2 core_data"},
          32'(core_data[i*DW +: DW]), 32'(m_data[i]));
      do_read(i + 1, v, s);
      chk(v == m_data[i], {tag, " R9 shadow readback"}, 32'(v), 32'(m_data[i]));
    end
    for (int i = 0; i < NLOC; i++) begin
      do_read(A_LOC0 + i, v, s);
      chk(v == m_loc[i], {tag, " R5 local readback"}, 32'(v), 32'(m_loc[i]));
    end
    do_read(0, v, s);
    chk(v == {{(DW-1){1'b0}}, m_en}, {tag, " R8 ctrl readback"}, 32'(v), 32'(m_en));
  endtask

  task automatic random_burst(input string tag, input int n);
    int a, s;
    logic [DW-1:0] d, b;
    for (int i = 0; i < n; i++) begin
      a = $urandom_range(0, NDATA + NLOC + 1);
      d = DW'($urandom);
      if (a == 0 && $urandom_range(0, 5) != 0) d[1] = 1'b0;
      do_write(a, d, s);
      if ($urandom_range(0, 1) == 1) begin
        do_read(A_BUSY, b, s);
        chk(s == 0, {tag, " R6 read no stall"}, 32'(s), 0);
        if (a <= NDATA)
          chk(32'(b) == exp_busy(a, d), {tag, " R3 busy vector"}, 32'(b), exp_busy(a, d));
      end
    end
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk_bus);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4 watchdog expired act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s;
    logic [DW-1:0] v;
    void'($urandom(32'd1234));
    m_en = 1'b0;
    for (int i = 0; i < NDATA; i++) m_data[i] = '0;
    for (int i = 0; i < NLOC; i++) m_loc[i] = '0;

    repeat (3) @(negedge clk_core);
    rst_core_n = 1'b1;
    repeat (3) @(negedge clk_bus);
    rst_bus_n = 1'b1;

    // reset state
    #1;
    chk(core_enable == 1'b0 && core_data == '0, "R2 reset core outputs", 32'(core_data), 0);
    do_read(A_BUSY, v, s);
    chk(v == '0, "R3 busy zero after reset", 32'(v), 0);

    // R1 / R3: single data write shows its own busy bit
    do_write(2, 16'hA5C3, s);
    do_read(A_BUSY, v, s);
    chk(32'(v) == exp_busy(2, 16'hA5C3), "R1 busy bit for data 2", 32'(v), exp_busy(2, 16'hA5C3));
    chk(s == 0, "R6 read during busy not stalled", 32'(s), 0);
    // R4: back-to-back write stalls, then lands
    do_write(3, 16'h1234, s);
    chk(s > 0, "R4 write during busy stalled", 32'(s), 1);
    do_read(A_BUSY, v, s);
    chk(32'(v) == exp_busy(3, 16'h1234), "R1 busy bit for data 3", 32'(v), exp_busy(3, 16'h1234));
    check_all("dir1");

    // R5: local write completes at once, no busy
    do_write(A_LOC0, 16'h0F0F, s);
    chk(s == 0, "R5 local write no stall", 32'(s), 0);
    do_read(A_BUSY, v, s);
    chk(v == '0, "R5 local write no busy", 32'(v), 0);

    // R3: busy address is read-only
    do_write(A_BUSY, 16'hFFFF, s);
    do_read(A_BUSY, v, s);
    chk(v == '0, "R3 busy write ignored", 32'(v), 0);

    // R8: enable write
    do_write(0, 16'h0001, s);
    do_read(A_BUSY, v, s);
    chk(v == 16'h2, "R8 enable busy bit", 32'(v), 32'h2);
    check_all("enable");

    // R7: gated interface clock
    @(negedge clk_bus);
    if_clk_on = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(1); req_wdata = 16'hBEEF;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_bus); #1;
      chk(!req_ready, "R7 gated access blocked", 32'(req_ready), 0);
    end
    chk(core_data[0 +: DW] == m_data[0], "R7 no write while gated",
        32'(core_data[0 +: DW]), 32'(m_data[0]));
    if_clk_on = 1'b1;
    #1;
    chk(req_ready, "R7 access completes after ungate", 32'(req_ready), 1);
    @(posedge clk_bus); #1;
    req_valid = 1'b0; req_write = 1'b0;
    model_wr(1, 16'hBEEF);
    check_all("ungate");

    // R9: software reset
    saw_rst = 1'b0;
    do_write(0, 16'h0002, s);
    do_read(A_BUSY, v, s);
    chk(v == 16'h3, "R9 reset busy bits", 32'(v), 32'h3);
    check_all("swrst");
    chk(saw_rst, "R9 reset phase observed", 32'(saw_rst), 1);
    chk(core_rst_active == 1'b0, "R9 reset phase over when busy clear", 32'(core_rst_active), 0);

    // R10: slow core clock random traffic
    random_burst("slow R10", 60);
    // R10: fast core clock random traffic
    core_half = 2.0;
    repeat (20) @(negedge clk_bus);
    do_write(2, 16'h7E57, s);
    do_write(0, 16'h0002, s);
    check_all("fast swrst R9");
    random_burst("fast R10", 60);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule